// File: doc/BRIEF.md
# Multichannel Sample Sequencer for a Shared Filter

Several slow decimator channels feed one filter that is time-shared among them. This block sits between the two. Each channel raises a one-cycle ready pulse with a data word. The block latches that word into a per-channel holding register and marks it pending. A single channel counter visits the channels in ascending order. When the channel it points at has a pending word, the block forwards the word on the shared output and clears the pending mark. The output word carries the channel number and a one-cycle valid strobe.

The filter relies on receiving the channels in a strict rotation. For that reason the sequencer never skips a channel. If the current channel has nothing pending, the counter stops there until a word arrives, even if other channels are waiting. Input words arrive roughly once per channel every two thousand clocks, so this wait costs nothing in practice. A channel that fires again before its previous word has been forwarded overwrites that word and raises a sticky overrun flag for that channel.

Top module: `chan_seq_mux`

## Requirements
- R1: A synchronous reset clears every pending mark and every overrun flag, deasserts `out_vld_o` and returns the channel counter to 0, so the first word forwarded after reset comes from channel 0.
- R2: A ready pulse latches that channel's data word. The latched value is what is later forwarded, even if the data input changes while the word waits.
- R3: Channels are served strictly in ascending index order. While the current channel has no pending word, no output is produced and the counter does not move, even if other channels hold words.
- R4: After channel NUM_CH-1 is served, the counter wraps to channel 0.
- R5: Each forwarded word appears with `out_vld_o` high for exactly one cycle. `out_ch_o` carries the unsigned channel index in the same cycle.
- R6: If a word is latched at clock edge k and its channel is current, `out_vld_o` is high after edge k+1.
- R7: Words pending on consecutive channels are forwarded on consecutive cycles.
- R8: A ready pulse on a channel whose word is still pending, and is not being forwarded in that cycle, sets bit `ch` of `overrun_o`. The newer word replaces the older one.
- R9: An overrun bit stays set until reset, including after the channel is served.
- R10: A ready pulse in the same cycle that the channel's current word is being forwarded does not count as an overrun. The old word goes out, and the new word waits for the channel's next turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_rdy_i | input | NUM_CH | Per-channel ready pulse; bit i belongs to channel i |
| ch_data_i | input | NUM_CH*DATA_W | Per-channel data words; element i belongs to channel i |
| out_vld_o | output | 1 | One-cycle strobe marking a forwarded word |
| out_ch_o | output | $clog2(NUM_CH) | Channel index of the forwarded word |
| out_data_o | output | DATA_W | Forwarded data word |
| overrun_o | output | NUM_CH | Sticky per-channel overrun flags |

## Verification
The bench builds the block with its defaults: eight channels, 16-bit words and a 3-bit channel tag. With only eight channels, a burst of ready pulses on every channel takes the counter through the 7-to-0 wrap within a few cycles. It also shows whether the output order follows the counter rather than the order in which words arrived. Sixteen-bit words are wide enough to tag every sample with a distinct value. That makes a stale word, an overwritten word or a swapped channel visible in the output data, not only in the channel tag.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int SQ_NUM_CH_DEF = 8;
    localparam int SQ_DATA_W_DEF = 16;

    // Next index in a ring of n slots
    function automatic logic [31:0] sq_next_idx(input logic [31:0] idx, input int unsigned n);
        return (idx == 32'(n - 1)) ? 32'd0 : idx + 32'd1;
    endfunction

endpackage

// File: rtl/sq_capture.sv
module sq_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic              pend;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (take_i) begin
            cap_d.pend = 1'b0;
        end
        if (rdy_i) begin
            cap_d.data = data_i;
            cap_d.pend = 1'b1;
            if (cap_q.pend && !take_i) begin
                cap_d.ovr = 1'b1;
            end
        end
        if (rst) begin
            cap_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign pend_o = cap_q.pend;
    assign data_o = cap_q.data;
    assign ovr_o  = cap_q.ovr;

    // R2: an untouched pending word keeps its value
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        pend_o && !rdy_i && !take_i |=> pend_o && $stable(data_o));

    // R8: a second pulse on a waiting word flags overrun
    p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
        pend_o && rdy_i && !take_i |=> ovr_o);

    // R9: overrun is sticky
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovr_o |=> ovr_o);

endmodule

// File: rtl/sq_order.sv
module sq_order
    import sq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             pend_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] data_i,
    output logic [NUM_CH-1:0]             take_o,
    output logic                          out_vld_o,
    output logic [CH_W-1:0]               out_ch_o,
    output logic [DATA_W-1:0]             out_data_o
);

    typedef struct packed {
        logic [CH_W-1:0]   cnt;
        logic              vld;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } ord_t;

    ord_t ord_d, ord_q;
    logic serve;

    always_comb begin
        ord_d  = ord_q;
        serve  = pend_i[ord_q.cnt];
        take_o = '0;
        ord_d.vld = 1'b0;
        if (serve) begin
            take_o[ord_q.cnt] = 1'b1;
            ord_d.vld  = 1'b1;
            ord_d.ch   = ord_q.cnt;
            ord_d.data = data_i[ord_q.cnt];
            ord_d.cnt  = CH_W'(sq_next_idx(32'(ord_q.cnt), NUM_CH));
        end
        if (rst) begin
            ord_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ord_q <= ord_d;
    end

    assign out_vld_o  = ord_q.vld;
    assign out_ch_o   = ord_q.ch;
    assign out_data_o = ord_q.data;

    // R3: at most one channel released per cycle
    p_one_take_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_o));

    // R3: an empty current channel stalls the rotation
    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        !pend_i[ord_q.cnt] |=> $stable(ord_q.cnt) && !out_vld_o);

endmodule

// File: rtl/chan_seq_mux.sv
module chan_seq_mux
    import sq_pkg::*;
#(
    parameter int NUM_CH = SQ_NUM_CH_DEF,
    parameter int DATA_W = SQ_DATA_W_DEF,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             ch_rdy_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_data_i,
    output logic                          out_vld_o,
    output logic [CH_W-1:0]               out_ch_o,
    output logic [DATA_W-1:0]             out_data_o,
    output logic [NUM_CH-1:0]             overrun_o
);

    logic [NUM_CH-1:0]             pend_w;
    logic [NUM_CH-1:0]             take_w;
    logic [NUM_CH-1:0][DATA_W-1:0] held_w;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cap
        sq_capture #(.DATA_W(DATA_W)) u_cap (
            .clk    (clk),
            .rst    (rst),
            .rdy_i  (ch_rdy_i[g]),
            .data_i (ch_data_i[g]),
            .take_i (take_w[g]),
            .pend_o (pend_w[g]),
            .data_o (held_w[g]),
            .ovr_o  (overrun_o[g])
        );
    end

    sq_order #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_order (
        .clk        (clk),
        .rst        (rst),
        .pend_i     (pend_w),
        .data_i     (held_w),
        .take_o     (take_w),
        .out_vld_o  (out_vld_o),
        .out_ch_o   (out_ch_o),
        .out_data_o (out_data_o)
    );

    // Independent rotation tracker used only by the checks below
    logic [CH_W-1:0] exp_ch_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            exp_ch_q <= '0;
        end else if (out_vld_o) begin
            exp_ch_q <= CH_W'(sq_next_idx(32'(exp_ch_q), NUM_CH));
        end
    end

    // R4: output tags follow the ring 0..NUM_CH-1 with wrap
    p_ring_order_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld_o |-> out_ch_o == exp_ch_q);

    // R3: nothing pending means nothing forwarded next cycle
    p_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !(|pend_w) |=> !out_vld_o);

endmodule

// File: tb/tb_chan_seq_mux.sv
module tb_chan_seq_mux;

    localparam int NCH = 8;
    localparam int DW  = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NCH-1:0]     rdy = '0;
    logic [NCH-1:0][DW-1:0] din = '0;
    logic               out_vld;
    logic [2:0]         out_ch;
    logic [DW-1:0]      out_data;
    logic [NCH-1:0]     ovr;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    chan_seq_mux #(.NUM_CH(NCH), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .ch_rdy_i(rdy), .ch_data_i(din),
        .out_vld_o(out_vld), .out_ch_o(out_ch), .out_data_o(out_data),
        .overrun_o(ovr)
    );

    // Output log sampled at falling edges
    int log_ch [0:63];
    int log_d  [0:63];
    int log_c  [0:63];
    int log_n = 0;
    int cyc = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && out_vld && log_n < 64) begin
            log_ch[log_n] = int'(out_ch);
            log_d[log_n]  = int'(out_data);
            log_c[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [NCH-1:0] mask, input int base);
        for (int i = 0; i < NCH; i++) begin
            if (mask[i]) din[i] = DW'(base + i);
        end
        rdy = mask;
        step();
        rdy = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rdy = '0;
        step(2);
        rst = 1'b0;
        chk(out_vld == 1'b0, "R1", "valid after reset", int'(out_vld), 0);
        chk(ovr == '0, "R1", "overrun after reset", int'(ovr), 0);
    endtask

    // R6, R5, R2, R1: first word after reset is channel 0, two edges after latch
    task automatic t_latency();
        log_n = 0;
        pulse(8'h01, 16'h0054);
        chk(out_vld == 1'b0, "R6", "valid one edge after latch", int'(out_vld), 0);
        step();
        chk(out_vld == 1'b1, "R6", "valid two edges after latch", int'(out_vld), 1);
        chk(out_ch == 3'd0, "R1", "first channel after reset", int'(out_ch), 0);
        chk(out_data == 16'h0054, "R2", "latched word", int'(out_data), 'h54);
        step();
        chk(out_vld == 1'b0, "R5", "valid lasts one cycle", int'(out_vld), 0);
    endtask

    // R3, R2, R7, R5: channel 3 waits for 1 and 2, then back-to-back release
    task automatic t_wait_order();
        log_n = 0;
        pulse(8'h08, 16'h00B0);
        din[3] = 16'hDEAD;
        step(5);
        chk(log_n == 0, "R3", "no output while current channel empty", log_n, 0);
        pulse(8'h06, 16'h0020);
        step(6);
        chk(log_n == 3, "R3", "word count", log_n, 3);
        chk(log_ch[0] == 1 && log_ch[1] == 2 && log_ch[2] == 3, "R3", "order 1,2,3",
            log_ch[0] * 256 + log_ch[1] * 16 + log_ch[2], 'h123);
        chk(log_d[0] == 'h21 && log_d[1] == 'h22, "R5", "data tagged with channel",
            log_d[0] * 256 + log_d[1], 'h2122);
        chk(log_d[2] == 'hB3, "R2", "held word despite input change", log_d[2], 'hB3);
        chk(log_c[1] == log_c[0] + 1 && log_c[2] == log_c[1] + 1, "R7",
            "consecutive cycles", log_c[2] - log_c[0], 2);
        chk(ovr == '0, "R8", "no overrun", int'(ovr), 0);
    endtask

    // R4, R7: all channels at once starting from counter 4
    task automatic t_wrap();
        bit ok_ch = 1'b1;
        bit ok_d = 1'b1;
        bit ok_c = 1'b1;
        log_n = 0;
        pulse(8'hFF, 16'h0100);
        step(12);
        chk(log_n == 8, "R4", "word count", log_n, 8);
        for (int k = 0; k < 8; k++) begin
            if (log_ch[k] != (4 + k) % 8) ok_ch = 1'b0;
            if (log_d[k] != 'h100 + (4 + k) % 8) ok_d = 1'b0;
            if (k > 0 && log_c[k] != log_c[k-1] + 1) ok_c = 1'b0;
        end
        chk(ok_ch, "R4", "order 4..7 then 0..3", log_ch[4], 0);
        chk(ok_d, "R5", "data matches tag", log_d[4], 'h100);
        chk(ok_c, "R7", "back-to-back across wrap", log_c[7] - log_c[0], 7);
    endtask

    // R8, R9, R1: overrun on a waiting channel
    task automatic t_overrun();
        log_n = 0;
        pulse(8'h40, 16'h0061 - 6);
        pulse(8'h40, 16'h0062 - 6);
        step();
        chk(ovr == 8'h40, "R8", "overrun bit of channel 6", int'(ovr), 'h40);
        chk(log_n == 0, "R3", "channel 6 waits for 4", log_n, 0);
        pulse(8'h30, 16'h0040);
        step(6);
        chk(log_n == 3 && log_ch[2] == 6, "R8", "channel 6 served third",
            log_ch[2], 6);
        chk(log_d[2] == 'h62, "R8", "newer word replaces older", log_d[2], 'h62);
        chk(ovr == 8'h40, "R9", "overrun stays after serve", int'(ovr), 'h40);
        do_reset();
    endtask

    // R10: new pulse in the serving cycle
    task automatic t_same_cycle();
        log_n = 0;
        din[0] = 16'h00A0;
        rdy = 8'h01;
        step();
        din[0] = 16'h00A1;
        step();
        rdy = '0;
        chk(out_vld == 1'b1 && out_ch == 3'd0, "R10", "old word forwarded",
            int'(out_ch), 0);
        chk(out_data == 16'h00A0, "R10", "old word value", int'(out_data), 'hA0);
        chk(ovr == '0, "R10", "no overrun on serve-cycle pulse", int'(ovr), 0);
        step();
        pulse(8'hFE, 16'h0300);
        step(12);
        chk(log_n == 9, "R10", "word count", log_n, 9);
        chk(log_ch[8] == 0 && log_d[8] == 'hA1, "R10", "new word on next turn",
            log_d[8], 'hA1);
    endtask

    initial begin
        step();
        do_reset();
        t_latency();
        t_wait_order();
        t_wrap();
        t_overrun();
        t_same_cycle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule